// File: doc/BRIEF.md
# Speculative Register Map with Pending-Writer Counters

This block is the register map table of a speculative thread. It keeps one entry per architectural register. Each entry holds three things: the last committed value, the reorder-buffer tag of the youngest speculative producer, and a small counter. The counter records how many speculative writers of that register are still uncommitted. Other logic reads the map to learn one of two things. Either the register is settled, and the committed value can be used. Or a producer is still in flight, and the consumer must wait for the result carrying the stored tag.

Dispatch goes through the rename port. While speculation runs normally, a dispatch records the new tag and raises the counter of its destination register. Retirement goes through the commit port. A retirement writes the retired value into the entry and lowers the counter.

A level input marks that trace speculation has begun. While it is high, dispatches are dropped entirely, but commits keep draining the counters toward zero. A commit that arrives at a counter already at zero is reported on an error output.

Top module: `spec_regmap`

## Requirements
- R1: After reset, every entry holds value 0, tag 0 and counter 0, so any read returns ready high with data 0.
- R2: A rename with `specOn` low writes `renTag` into the tag of register `renReg`, including when the counter is saturated.
- R3: A rename with `specOn` low increments the counter of `renReg`; the counter saturates at 15 and holds there on further renames.
- R4: A commit writes `cmtData` into the value of register `cmtReg` and decrements its counter when that counter is nonzero.
- R5: While `specOn` is high, renames change neither tag nor counter, and commits still write values and decrement counters.
- R6: A commit to a register whose counter is 0 raises `cmtUnderflow` in the same cycle, leaves the counter at 0 and still writes the value; otherwise `cmtUnderflow` is low.
- R7: A rename (with `specOn` low) and a commit that target the same register in one cycle leave its counter unchanged, write both tag and value, and do not raise `cmtUnderflow`.
- R8: The read port is combinational on the state after the last clock edge. With the counter of `rdReg` at 0, `rdReady` is 1 and `rdData` is the committed value. Otherwise `rdReady` is 0 and `rdData` carries the tag in bits 5:0, with the upper bits zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| renValid | input | 1 | Rename request valid |
| renReg | input | 5 | Destination register of the renamed instruction |
| renTag | input | 6 | Reorder-buffer tag of the renamed instruction |
| cmtValid | input | 1 | Commit request valid |
| cmtReg | input | 5 | Destination register of the committing instruction |
| cmtData | input | 32 | Result value being committed |
| specOn | input | 1 | High while trace speculation is active; suppresses renames |
| rdReg | input | 5 | Register index to look up |
| rdReady | output | 1 | Looked-up register has no pending writers |
| rdData | output | 32 | Committed value when ready, otherwise the tag zero-extended |
| cmtUnderflow | output | 1 | Commit hit a register whose counter is already 0 |

## Verification
The hardest state to reach is a counter held at saturation. That takes sixteen or more back-to-back renames to one register, and fifteen commits are then needed to bring it back to ready. The stimulus drives that run directly on one register. It also engages `specOn` while counters are nonzero, checking that renames are dropped and that the drain ends in an underflow. A random phase confined to eight registers then produces frequent same-register rename/commit collisions, and a reference model checks every cycle.

// File: rtl/regmap_pkg.sv
package regmap_pkg;
  typedef struct packed {
    logic incEn;   // bump counter of rename register
    logic decEn;   // drop counter of commit register
    logic tagWr;   // write tag of rename register
    logic valWr;   // write value of commit register
  } mapStrobe_t;
endpackage

// File: rtl/regmap_ctrl.sv
module regmap_ctrl
  import regmap_pkg::*;
#(
  parameter int NREG = 32,
  parameter int CW   = 4
) (
  input  logic                    renValid,
  input  logic [$clog2(NREG)-1:0] renReg,
  input  logic                    cmtValid,
  input  logic [$clog2(NREG)-1:0] cmtReg,
  input  logic                    specOn,
  input  logic [CW-1:0]           renCnt,
  input  logic [CW-1:0]           cmtCnt,
  output mapStrobe_t              strobe,
  output logic                    underflow
);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic renLive;
  logic sameReg;
  logic collide;

  assign renLive = renValid && !specOn;
  assign sameReg = (renReg == cmtReg);
  assign collide = renLive && cmtValid && sameReg;

  always_comb begin
    strobe       = '0;
    underflow    = 1'b0;
    strobe.tagWr = renLive;
    strobe.valWr = cmtValid;
    if (!collide) begin
      strobe.incEn = renLive && (renCnt != CMAX);
      strobe.decEn = cmtValid && (cmtCnt != '0);
      underflow    = cmtValid && (cmtCnt == '0);
    end
  end
endmodule

// File: rtl/regmap_dp.sv
module regmap_dp
  import regmap_pkg::*;
#(
  parameter int NREG = 32,
  parameter int DW   = 32,
  parameter int TW   = 6,
  parameter int CW   = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  mapStrobe_t              strobe,
  input  logic [$clog2(NREG)-1:0] renReg,
  input  logic [TW-1:0]           renTag,
  input  logic [$clog2(NREG)-1:0] cmtReg,
  input  logic [DW-1:0]           cmtData,
  input  logic [$clog2(NREG)-1:0] rdReg,
  output logic [CW-1:0]           renCnt,
  output logic [CW-1:0]           cmtCnt,
  output logic                    rdReady,
  output logic [DW-1:0]           rdData,
  output logic [NREG*CW-1:0]      cntFlat
);
  logic [DW-1:0] valArr [NREG];
  logic [TW-1:0] tagArr [NREG];
  logic [CW-1:0] cntArr [NREG];

  for (genvar i = 0; i < NREG; i++) begin : gEntry
    logic renHit;
    logic cmtHit;
    assign renHit = (renReg == i[$clog2(NREG)-1:0]);
    assign cmtHit = (cmtReg == i[$clog2(NREG)-1:0]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        valArr[i] <= '0;
        tagArr[i] <= '0;
        cntArr[i] <= '0;
      end else begin
        if (strobe.valWr && cmtHit) valArr[i] <= cmtData;
        if (strobe.tagWr && renHit) tagArr[i] <= renTag;
        if (strobe.incEn && renHit)      cntArr[i] <= cntArr[i] + 1'b1;
        else if (strobe.decEn && cmtHit) cntArr[i] <= cntArr[i] - 1'b1;
      end
    end

    assign cntFlat[i*CW +: CW] = cntArr[i];
  end

  assign renCnt  = cntArr[renReg];
  assign cmtCnt  = cntArr[cmtReg];
  assign rdReady = (cntArr[rdReg] == '0);
  assign rdData  = rdReady ? valArr[rdReg] : DW'(tagArr[rdReg]);
endmodule

// File: rtl/spec_regmap.sv
module spec_regmap
  import regmap_pkg::*;
#(
  parameter int NREG = 32,
  parameter int DW   = 32,
  parameter int TW   = 6,
  parameter int CW   = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    renValid,
  input  logic [$clog2(NREG)-1:0] renReg,
  input  logic [TW-1:0]           renTag,
  input  logic                    cmtValid,
  input  logic [$clog2(NREG)-1:0] cmtReg,
  input  logic [DW-1:0]           cmtData,
  input  logic                    specOn,
  input  logic [$clog2(NREG)-1:0] rdReg,
  output logic                    rdReady,
  output logic [DW-1:0]           rdData,
  output logic                    cmtUnderflow
);
  mapStrobe_t          strobe;
  logic [CW-1:0]       renCnt;
  logic [CW-1:0]       cmtCnt;
  logic [NREG*CW-1:0]  cntFlat;

  regmap_ctrl #(.NREG(NREG), .CW(CW)) uCtrl (
    .renValid (renValid),
    .renReg   (renReg),
    .cmtValid (cmtValid),
    .cmtReg   (cmtReg),
    .specOn   (specOn),
    .renCnt   (renCnt),
    .cmtCnt   (cmtCnt),
    .strobe   (strobe),
    .underflow(cmtUnderflow)
  );

  regmap_dp #(.NREG(NREG), .DW(DW), .TW(TW), .CW(CW)) uDp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .renReg (renReg),
    .renTag (renTag),
    .cmtReg (cmtReg),
    .cmtData(cmtData),
    .rdReg  (rdReg),
    .renCnt (renCnt),
    .cmtCnt (cmtCnt),
    .rdReady(rdReady),
    .rdData (rdData),
    .cntFlat(cntFlat)
  );
endmodule

// File: rtl/regmap_checker.sv
module regmap_checker #(
  parameter int NREG = 32,
  parameter int CW   = 4
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    renValid,
  input logic [$clog2(NREG)-1:0] renReg,
  input logic                    cmtValid,
  input logic [$clog2(NREG)-1:0] cmtReg,
  input logic                    specOn,
  input logic [$clog2(NREG)-1:0] rdReg,
  input logic                    rdReady,
  input logic                    cmtUnderflow,
  input logic [NREG*CW-1:0]      cntFlat
);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  function automatic logic [CW-1:0] cntOf(logic [NREG*CW-1:0] flat,
                                          logic [$clog2(NREG)-1:0] idx);
    return flat[idx*CW +: CW];
  endfunction

  AST_INC_ON_RENAME: assert property (@(posedge clk) disable iff (!rstN)
    (renValid && !specOn && !cmtValid && cntOf(cntFlat, renReg) != CMAX)
    |=> cntOf(cntFlat, $past(renReg)) == $past(cntOf(cntFlat, renReg)) + 1'b1); // R3

  AST_SATURATE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (renValid && !cmtValid && cntOf(cntFlat, renReg) == CMAX)
    |=> cntOf(cntFlat, $past(renReg)) == CMAX); // R3

  AST_DEC_ON_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    (cmtValid && !renValid && cntOf(cntFlat, cmtReg) != '0)
    |=> cntOf(cntFlat, $past(cmtReg)) == $past(cntOf(cntFlat, cmtReg)) - 1'b1); // R4

  AST_FROZEN_NO_GROWTH: assert property (@(posedge clk) disable iff (!rstN)
    (specOn && !cmtValid) |=> $stable(cntFlat)); // R5

  AST_UNDERFLOW_AT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    cmtUnderflow |-> (cmtValid && cntOf(cntFlat, cmtReg) == '0)); // R6

  AST_COLLIDE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (renValid && !specOn && cmtValid && renReg == cmtReg)
    |-> !cmtUnderflow ##1 $stable(cntFlat)); // R7

  AST_READY_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    rdReady == (cntOf(cntFlat, rdReg) == '0)); // R8
endmodule

bind spec_regmap regmap_checker #(.NREG(NREG), .CW(CW)) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .renValid    (renValid),
  .renReg      (renReg),
  .cmtValid    (cmtValid),
  .cmtReg      (cmtReg),
  .specOn      (specOn),
  .rdReg       (rdReg),
  .rdReady     (rdReady),
  .cmtUnderflow(cmtUnderflow),
  .cntFlat     (cntFlat)
);

// File: tb/spec_regmap_test.sv
module spec_regmap_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        renValid = 1'b0;
  logic [4:0]  renReg = '0;
  logic [5:0]  renTag = '0;
  logic        cmtValid = 1'b0;
  logic [4:0]  cmtReg = '0;
  logic [31:0] cmtData = '0;
  logic        specOn = 1'b0;
  logic [4:0]  rdReg = '0;
  logic        rdReady;
  logic [31:0] rdData;
  logic        cmtUnderflow;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  logic [31:0] mVal [32];
  logic [5:0]  mTag [32];
  int          mCnt [32];

  spec_regmap uut (
    .clk(clk), .rstN(rstN),
    .renValid(renValid), .renReg(renReg), .renTag(renTag),
    .cmtValid(cmtValid), .cmtReg(cmtReg), .cmtData(cmtData),
    .specOn(specOn), .rdReg(rdReg),
    .rdReady(rdReady), .rdData(rdData), .cmtUnderflow(cmtUnderflow)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic cycle(input bit rv, input int rr, input int rt,
                       input bit cv, input int cr, input logic [31:0] cd,
                       input bit so, input int rd, input string tag);
    bit          renLive;
    bit          expUf;
    bit          expRdy;
    logic [31:0] expData;
    @(negedge clk);
    renValid = rv; renReg = 5'(rr); renTag = 6'(rt);
    cmtValid = cv; cmtReg = 5'(cr); cmtData = cd;
    specOn = so; rdReg = 5'(rd);
    #1;
    renLive = rv && !so;
    expUf   = cv && !(renLive && rr == cr) && mCnt[cr] == 0;
    expRdy  = (mCnt[rd] == 0);
    expData = expRdy ? mVal[rd] : {26'b0, mTag[rd]};
    checks++;
    if (cmtUnderflow !== expUf) begin
      fails++;
      $display("FAIL R6 underflow (%s): got %0b expected %0b", tag, cmtUnderflow, expUf);
    end
    checks++;
    if (rdReady !== expRdy || rdData !== expData) begin
      fails++;
      $display("FAIL %s read r%0d: got rdy=%0b data=%h expected rdy=%0b data=%h",
               tag, rd, rdReady, rdData, expRdy, expData);
    end
    @(posedge clk);
    if (renLive && cv && rr == cr) begin
      mTag[rr] = 6'(rt);
      mVal[cr] = cd;
    end else begin
      if (renLive) begin
        mTag[rr] = 6'(rt);
        if (mCnt[rr] < 15) mCnt[rr]++;
      end
      if (cv) begin
        mVal[cr] = cd;
        if (mCnt[cr] > 0) mCnt[cr]--;
      end
    end
  endtask

  task automatic idleRead(input int rd, input string tag);
    cycle(0, 0, 0, 0, 0, 32'h0, 0, rd, tag);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish();
  end

  initial begin
    for (int i = 0; i < 32; i++) begin
      mVal[i] = '0; mTag[i] = '0; mCnt[i] = 0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset contents
    for (int i = 0; i < 32; i++) idleRead(i, "R1");

    // R2 R3 R4: two renames then two commits on r5
    cycle(1, 5, 7, 0, 0, 0, 0, 5, "R2");
    cycle(1, 5, 9, 0, 0, 0, 0, 5, "R2");
    idleRead(5, "R3");
    cycle(0, 0, 0, 1, 5, 32'hAAAA_0001, 0, 5, "R4");
    cycle(0, 0, 0, 1, 5, 32'hBBBB_0002, 0, 5, "R4");
    idleRead(5, "R4");

    // R3: saturation on r9, then drain with fifteen commits
    for (int i = 0; i < 17; i++) cycle(1, 9, i + 20, 0, 0, 0, 0, 9, "R3");
    for (int i = 0; i < 15; i++) cycle(0, 0, 0, 1, 9, 32'h900 + i, 0, 9, "R3");
    idleRead(9, "R3");

    // R6: commit at zero still writes
    cycle(0, 0, 0, 1, 3, 32'hDEAD_BEEF, 0, 3, "R6");
    idleRead(3, "R6");

    // R7: collisions at nonzero and zero counts
    cycle(1, 4, 11, 0, 0, 0, 0, 4, "R7");
    cycle(1, 4, 12, 1, 4, 32'h44, 0, 4, "R7");
    idleRead(4, "R7");
    cycle(0, 0, 0, 1, 4, 32'h45, 0, 4, "R7");
    idleRead(4, "R7");
    cycle(1, 6, 13, 1, 6, 32'h66, 0, 6, "R7");
    idleRead(6, "R7");

    // R5: freeze then drain into underflow
    for (int i = 0; i < 3; i++) cycle(1, 10, 30 + i, 0, 0, 0, 1'b0, 10, "R5");
    cycle(1, 10, 50, 0, 0, 0, 1, 10, "R5");
    cycle(1, 11, 51, 0, 0, 0, 1, 11, "R5");
    idleRead(11, "R5");
    for (int i = 0; i < 4; i++) cycle(1, 10, 52, 1, 10, 32'hA0 + i, 1, 10, "R5");
    idleRead(10, "R5");

    // R8 with mixed traffic: random phase over eight registers
    for (int n = 0; n < 3000; n++) begin
      cycle($urandom_range(0, 1), $urandom_range(0, 7), $urandom_range(0, 63),
            $urandom_range(0, 1), $urandom_range(0, 7), $urandom,
            ($urandom_range(0, 7) == 0), $urandom_range(0, 7), "R8");
    end

    finish();
  end
endmodule